// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block turns parallel characters into start/stop framed asynchronous frames on one transmit line. Four mode inputs select the frame format: a 7 or 8 bit character, parity present or absent, even or odd parity, and one or two stop bits. The first three choices that change the frame's length give eight formats. The parity sense then picks the value of the parity bit.

Characters go through two stages. A write places a character in a holding register. The holding register hands it to a frame shifter as soon as the shifter is free. Because of this, the next character can be written while the current frame is still on the line, and frames then follow with no idle gap between them. Bit timing comes from an external enable that pulses at sixteen times the bit rate. The block itself has no baud generator and no interrupt logic.

Top module: `sertx_top`

## Requirements
- R1: After reset the line is high, `hold_empty` is 1 and `tx_done` is 1. Whenever no frame is being shifted, the line stays high.
- R2: A frame starts with one low start bit. The line drops in the cycle after the holding register transfers to the shifter.
- R3: After the start bit come the character bits, least significant first. When `mode_seven`=1 there are 7 of them, taken from `wr_data[6:0]`, and `wr_data[7]` is not sent. When `mode_seven`=0 all 8 bits are sent.
- R4: When `mode_parity`=1, one parity bit follows the last character bit. With `mode_odd`=0 the parity bit and the sent character bits together hold an even number of ones. With `mode_odd`=1 they hold an odd number.
- R5: The frame ends with high stop bits: two when `mode_two_stop`=1 and one when it is 0.
- R6: Every bit lasts exactly 16 cycles in which `tick`=1. In a cycle with `tick`=0 the line does not change while a frame is in progress.
- R7: The mode inputs are taken at the moment of transfer. Changing them during a frame has no effect on that frame.
- R8: A write clears `hold_empty` on the next edge. A transfer sets it again. A transfer happens when the shifter is idle, or on the tick that ends the last stop bit, so that the next frame follows with no gap.
- R9: If a write arrives in the same cycle as a transfer, the character already held is the one sent. The new character stays held and `hold_empty` remains 0.
- R10: `tx_done` goes to 1 on the tick that ends the last stop bit when the holding register is empty. A write clears it on the next edge.
- R11: A write while the holding register is full replaces the held character. Only the newer character is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick | input | 1 | Serial clock enable, sixteen pulses per bit |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Character to write |
| mode_seven | input | 1 | 1 selects a 7-bit character, 0 selects 8 bits |
| mode_parity | input | 1 | 1 appends a parity bit |
| mode_odd | input | 1 | 1 selects odd parity, 0 selects even parity |
| mode_two_stop | input | 1 | 1 selects two stop bits, 0 selects one |
| txd | output | 1 | Serial line output, high when idle |
| hold_empty | output | 1 | Holding register can accept a character |
| tx_done | output | 1 | Last frame finished and nothing is pending |

## Verification
The write strobe and the hand-over from the holding register to the shifter can land in the same clock edge. This happens at the tick that closes the final stop bit while a character is already held. The bench provokes it by watching its own model for the cycle in which that tick is being driven, and asserts `wr_en` in exactly that cycle. The result is judged on the line and the flags: the older character must be the next frame, the newer one must follow it directly, and `hold_empty` must never rise in between.

// File: rtl/sertx_pkg.sv
// Shared types and frame-building helpers for the serial transmitter.
// Assumes at most an 8-bit character, one parity bit and two stop bits.
package sertx_pkg;

    localparam int MAX_DATA  = 8;
    localparam int FRAME_MAX = MAX_DATA + 4;           // start + parity + two stops
    localparam int LEFT_W    = $clog2(FRAME_MAX + 1);

    typedef struct packed {
        logic short_len;   // 7-bit character
        logic par_on;      // parity bit present
        logic par_odd;     // odd parity sense
        logic two_stop;    // two stop bits
    } txfmt_t;

    // Number of bit periods in a frame of the given format.
    function automatic logic [LEFT_W-1:0] frame_bits(input txfmt_t f);
        int n;
        n = 1 + (f.short_len ? MAX_DATA - 1 : MAX_DATA)
              + (f.par_on ? 1 : 0) + (f.two_stop ? 2 : 1);
        return LEFT_W'(n);
    endfunction

    // Line levels of a whole frame, bit 0 is sent first; unused top bits are mark.
    function automatic logic [FRAME_MAX-1:0] pack_frame(input logic [MAX_DATA-1:0] d,
                                                        input txfmt_t f);
        logic [FRAME_MAX-1:0] fr;
        logic par;
        int n;
        fr    = '1;
        fr[0] = 1'b0;
        par   = f.par_odd;
        n     = f.short_len ? MAX_DATA - 1 : MAX_DATA;
        for (int i = 0; i < MAX_DATA; i++) begin
            if (i < n) begin
                fr[i+1] = d[i];
                par     = par ^ d[i];
            end else if (i == n && f.par_on) begin
                fr[i+1] = par;
            end
        end
        if (f.par_on && n == MAX_DATA) fr[MAX_DATA+1] = par;
        return fr;
    endfunction

endpackage

// File: rtl/sertx_bit_pacer.sv
// Counts serial-clock enables inside one bit period and flags the last one.
// Assumes TICKS_PER_BIT >= 2; the count restarts whenever a frame is loaded.
module sertx_bit_pacer #(
    parameter int TICKS_PER_BIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic run,
    input  logic restart,
    output logic bit_end
);
    localparam int CNT_W = $clog2(TICKS_PER_BIT);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TICKS_PER_BIT - 1);

    logic [CNT_W-1:0] cnt;

    assign bit_end = run && tick && (cnt == LAST);

    // Advance the in-bit tick count while a frame is running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (restart) begin
            cnt <= '0;
        end else if (run && tick) begin
            cnt <= bit_end ? '0 : cnt + 1'b1;
        end
    end
endmodule

// File: rtl/sertx_hold_reg.sv
// Holding stage: keeps one character until the shifter takes it.
// A write wins over a take in the same cycle; a write when full overwrites.
module sertx_hold_reg #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              take,
    output logic [DATA_W-1:0] hold_data,
    output logic              hold_empty
);
    // Capture writes and mark the stage empty after a hand-over.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_data  <= '0;
            hold_empty <= 1'b1;
        end else if (wr_en) begin
            hold_data  <= wr_data;
            hold_empty <= 1'b0;
        end else if (take) begin
            hold_empty <= 1'b1;
        end
    end
endmodule

// File: rtl/sertx_frame_shifter.sv
// Builds a complete frame at load time and shifts it out LSB first.
// Assumes bit_end pulses once per bit period while busy; the line is mark when idle.
module sertx_frame_shifter
    import sertx_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic [MAX_DATA-1:0] load_data,
    input  txfmt_t              load_fmt,
    input  logic                bit_end,
    output logic                txd,
    output logic                busy,
    output logic                frame_end
);
    logic [FRAME_MAX-1:0] sr;
    logic [LEFT_W-1:0]    left;

    assign busy      = (left != '0);
    assign frame_end = bit_end && (left == LEFT_W'(1));
    assign txd       = busy ? sr[0] : 1'b1;

    // Load a fresh frame or move to the next bit at each bit boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr   <= '1;
            left <= '0;
        end else if (load) begin
            sr   <= pack_frame(load_data, load_fmt);
            left <= frame_bits(load_fmt);
        end else if (bit_end) begin
            sr   <= {1'b1, sr[FRAME_MAX-1:1]};
            left <= left - 1'b1;
        end
    end
endmodule

// File: rtl/sertx_top.sv
// Double-buffered asynchronous serial transmitter with run-time frame format.
// Assumes tick is a one-cycle enable at sixteen times the bit rate.
module sertx_top
    import sertx_pkg::*;
#(
    parameter int TICKS_PER_BIT = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic                wr_en,
    input  logic [MAX_DATA-1:0] wr_data,
    input  logic                mode_seven,
    input  logic                mode_parity,
    input  logic                mode_odd,
    input  logic                mode_two_stop,
    output logic                txd,
    output logic                hold_empty,
    output logic                tx_done
);
    txfmt_t              fmt;
    logic [MAX_DATA-1:0] hold_data;
    logic                shift_busy;
    logic                frame_end;
    logic                bit_end;
    logic                load;

    assign fmt  = '{short_len: mode_seven, par_on: mode_parity,
                    par_odd: mode_odd, two_stop: mode_two_stop};
    assign load = !hold_empty && (!shift_busy || frame_end);

    sertx_hold_reg #(.DATA_W(MAX_DATA)) u_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .take       (load),
        .hold_data  (hold_data),
        .hold_empty (hold_empty)
    );

    sertx_bit_pacer #(.TICKS_PER_BIT(TICKS_PER_BIT)) u_pace (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .run     (shift_busy),
        .restart (load),
        .bit_end (bit_end)
    );

    sertx_frame_shifter u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .load_data (hold_data),
        .load_fmt  (fmt),
        .bit_end   (bit_end),
        .txd       (txd),
        .busy      (shift_busy),
        .frame_end (frame_end)
    );

    // Raise completion when the line drains with nothing pending; a write clears it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_done <= 1'b1;
        end else if (wr_en) begin
            tx_done <= 1'b0;
        end else if (frame_end && hold_empty) begin
            tx_done <= 1'b1;
        end
    end
endmodule

// File: rtl/sertx_top_chk.sv
// Temporal checks for the serial transmitter, attached to every sertx_top.
module sertx_top_chk (
    input logic clk,
    input logic rst_n,
    input logic tick,
    input logic wr_en,
    input logic txd,
    input logic hold_empty,
    input logic tx_done,
    input logic busy
);
    a_r1_idle_mark: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> txd);

    a_r2_start_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !txd);

    a_r6_no_tick_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !tick) |=> $stable(txd));

    a_r8_write_fills: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !hold_empty);

    a_r10_write_clears_done: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !tx_done);

    a_r10_done_means_idle: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |-> (!busy && hold_empty && txd));
endmodule

bind sertx_top sertx_top_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .wr_en      (wr_en),
    .txd        (txd),
    .hold_empty (hold_empty),
    .tx_done    (tx_done),
    .busy       (shift_busy)
);

// File: tb/sertx_top_tb.sv
module sertx_top_tb;
    localparam int TPB = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       mode_seven = 1'b0, mode_parity = 1'b0, mode_odd = 1'b0, mode_two_stop = 1'b0;
    logic       txd, hold_empty, tx_done;

    always #5 clk = ~clk;

    sertx_top #(.TICKS_PER_BIT(TPB)) u_dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_data(wr_data),
        .mode_seven(mode_seven), .mode_parity(mode_parity), .mode_odd(mode_odd),
        .mode_two_stop(mode_two_stop), .txd(txd), .hold_empty(hold_empty), .tx_done(tx_done)
    );

    int    checks = 0, errors = 0, cyc = 0;
    string phase = "R1";
    bit    cmp_on = 1'b0;

    // Reference model state
    bit       m_q[$];
    int       m_sub = 0;
    bit       m_full = 0, m_done = 1;
    logic [7:0] m_hold = 8'h00;
    bit       m_busy, m_fe, m_ld;

    // Tick generator: fixed divider or pseudo-random pattern
    int         tick_div = 1, tcnt = 0;
    bit         tick_rand = 0;
    logic [15:0] lfsr = 16'hACE1;
    always @(negedge clk) begin
        tcnt++;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        tick = tick_rand ? lfsr[0] : ((tcnt % tick_div) == 0);
    end

    task automatic model_load(input logic [7:0] d);
        int n;
        bit p;
        n = mode_seven ? 7 : 8;
        p = mode_odd;
        m_q.push_back(1'b0);
        for (int i = 0; i < n; i++) begin
            m_q.push_back(d[i]);
            if (d[i]) p = !p;
        end
        if (mode_parity) m_q.push_back(p);
        m_q.push_back(1'b1);
        if (mode_two_stop) m_q.push_back(1'b1);
    endtask

    // Behavioural model step on each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_q.delete();
            m_sub = 0; m_full = 0; m_hold = 8'h00; m_done = 1;
        end else begin
            m_busy = (m_q.size() != 0);
            m_fe   = m_busy && tick && m_sub == TPB - 1 && m_q.size() == 1;
            m_ld   = m_full && (!m_busy || m_fe);
            if (m_busy && tick) begin
                if (m_sub == TPB - 1) begin
                    void'(m_q.pop_front());
                    m_sub = 0;
                end else begin
                    m_sub++;
                end
            end
            if (m_ld) begin
                model_load(m_hold);
                m_sub = 0;
            end
            if (wr_en) m_done = 0;
            else if (m_fe && !m_full) m_done = 1;
            if (wr_en) begin m_full = 1; m_hold = wr_data; end
            else if (m_ld) m_full = 0;
        end
    end

    task automatic check1(input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%b expected=%b at t=%0t", phase, what, act, exp, $time);
        end
    endtask

    // Compare outputs with the model away from the active edge
    always @(negedge clk) begin
        if (cmp_on) begin
            check1("txd", txd, (m_q.size() != 0) ? m_q[0] : 1'b1);
            check1("hold_empty", hold_empty, !m_full);
            check1("tx_done", tx_done, m_done);
        end
    end

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL R10 watchdog: actual cycles=%0d expected below 150000", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic send(input logic [7:0] d);
        @(negedge clk); #1;
        wr_en = 1'b1; wr_data = d;
        @(negedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic set_mode(input bit s, input bit p, input bit o, input bit t);
        @(negedge clk); #1;
        mode_seven = s; mode_parity = p; mode_odd = o; mode_two_stop = t;
    endtask

    task automatic wait_done();
        forever begin
            @(negedge clk); #1;
            if (m_done) break;
        end
    endtask

    task automatic wait_hold_free();
        forever begin
            @(negedge clk); #1;
            if (!m_full) break;
        end
    endtask

    // Write in exactly the cycle where the held character is handed over
    task automatic write_at_transfer(input logic [7:0] d);
        forever begin
            @(negedge clk); #1;
            if (tick && m_full && m_q.size() == 1 && m_sub == TPB - 1) break;
        end
        wr_en = 1'b1; wr_data = d;
        @(negedge clk); #1;
        wr_en = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1 rst_n = 1'b1;
        cmp_on = 1'b1;

        phase = "R1";
        repeat (6) @(negedge clk);

        phase = "R2 R3 R6";
        set_mode(0, 0, 0, 0);
        send(8'hA5); wait_done();

        phase = "R3";
        set_mode(1, 0, 0, 0);
        send(8'hFF); wait_done();
        send(8'h80); wait_done();

        phase = "R4";
        set_mode(0, 1, 0, 0);
        send(8'h03); wait_done();
        send(8'h07); wait_done();
        set_mode(1, 1, 1, 0);
        send(8'h80); wait_done();
        send(8'h81); wait_done();

        phase = "R5";
        set_mode(0, 0, 0, 1);
        send(8'h5A); wait_done();

        phase = "R2 R3 R4 R5 all formats";
        for (int f = 0; f < 16; f++) begin
            tick_div = 1 + (f % 3);
            set_mode(f[0], f[1], f[2], f[3]);
            send(8'(f * 17 + 3)); wait_done();
        end
        tick_div = 1;

        phase = "R6";
        tick_rand = 1;
        set_mode(0, 1, 0, 1);
        send(8'h3C); wait_done();
        tick_rand = 0;

        phase = "R7";
        set_mode(0, 0, 0, 0);
        send(8'hC3);
        repeat (40) @(negedge clk);
        set_mode(1, 1, 1, 1);
        wait_done();

        phase = "R8";
        set_mode(0, 1, 1, 0);
        send(8'h12); send(8'h34);
        wait_hold_free();
        send(8'h56);
        wait_done();

        phase = "R9";
        set_mode(0, 0, 0, 0);
        send(8'h11); send(8'h22);
        write_at_transfer(8'h33);
        wait_done();

        phase = "R11";
        send(8'h44); send(8'h55); send(8'h66);
        wait_done();

        phase = "R10";
        repeat (20) @(negedge clk);

        cmp_on = 1'b0;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule